// File: doc/BRIEF.md
# Accumulator Round and Store Saturation

This block turns a 40-bit signed accumulator value into a 16-bit 1.15 fractional word that is ready to be written to data memory. The accumulator is split into three parts. The upper 8 bits are guard bits. The middle 16 bits (bits 31..16) are the high word that is stored. The low 16 bits are the fraction that is rounded away or dropped.

Two rounding styles are offered, both selected per store:
- **Biased rounding** adds one to the high word whenever the dropped fraction is at least one half.
- **Unbiased rounding** breaks an exact half tie toward an even high word.

When rounding is off, the high word is truncated. A store saturation stage then optionally clamps the result to the 1.15 range. It takes the sign of the value from the accumulator's top bit. The block is purely combinational and only reads the accumulator, so the source value is never altered.

The block has no states and no transitions. A new result appears on `store_word` in the same cycle that the inputs change.

Top module: `acc_store_conv`

## Requirements
- R1: With `round_en`=0 and `sat_en`=0, `store_word` equals `acc_val[31:16]`; the low 16 bits have no effect.
- R2: With `round_en`=1 and `round_mode`=0 (biased), the high word `acc_val[31:16]` is incremented when `acc_val[15:0]` ≥ 0x8000, and is left unchanged otherwise.
- R3: With `round_en`=1 and `round_mode`=1 (unbiased), results equal the biased results for every low word other than exactly 0x8000.
- R4: With `round_en`=1, `round_mode`=1 and `acc_val[15:0]`=0x8000, the high word is incremented only when `acc_val[16]`=1.
- R5: With `sat_en`=1 and `acc_val[39]`=0, a rounded value `acc_val[39:16]`+increment above 0x007FFF gives 0x7FFF. This includes 0x7FFF plus a rounding carry.
- R6: With `sat_en`=1 and `acc_val[39]`=1, a rounded value below 0xFF8000 (signed) gives 0x8000.
- R7: With `sat_en`=1 and a rounded value inside [0xFF8000, 0x007FFF], `store_word` is the low 16 bits of that rounded value.
- R8: With `sat_en`=0, `store_word` is the low 16 bits of the rounded or truncated value, which wraps with no clamping.
- R9: With `round_en`=0, `round_mode` has no effect on `store_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_val | input | 40 | Signed accumulator value to store (bits 39..32 guard, 31..16 high word, 15..0 fraction) |
| round_en | input | 1 | 1 = round the high word, 0 = truncate |
| round_mode | input | 1 | 0 = biased rounding, 1 = unbiased (tie to even) |
| sat_en | input | 1 | 1 = clamp the stored word to the 1.15 range |
| store_word | output | 16 | 1.15 word to be written to memory |

## Verification
Because the block has no registers, any fault in the rounding increment or the clamp shows on `store_word` in the same cycle the inputs are applied.

- A tie-break fault shows only when the fraction is exactly 0x8000, so those vectors are applied with both parities of bit 16.
- A carry-width fault shows only when 0x7FFF is rounded up, which appears as a wrap to 0x8000 instead of a clamp to 0x7FFF.
- A fault in the sign source shows only for values whose guard bits disagree with bit 31.

Random values with heavy guard bits are therefore run in every combination of `round_en`, `round_mode` and `sat_en`.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;

    // Rounding style selector; the encoding matches the round_mode pin.
    typedef enum logic {
        RND_BIASED   = 1'b0,
        RND_UNBIASED = 1'b1
    } rnd_style_e;

endpackage

// File: rtl/acc_round_unit.sv
module acc_round_unit
    import acc_store_pkg::*;
#(
    parameter  int ACC_W = 40,
    parameter  int LO_W  = 16,
    localparam int SUM_W = ACC_W - LO_W + 1
) (
    input  logic [ACC_W-1:0]        acc_i,
    input  logic                    round_en_i,
    input  rnd_style_e              style_i,
    output logic signed [SUM_W-1:0] sum_o,
    output logic                    inc_o
);

    localparam logic [LO_W-1:0] HALF_CODE = {1'b1, {(LO_W-1){1'b0}}};

    logic [LO_W-1:0] frac;
    logic            frac_half;
    logic            frac_above;
    logic            high_odd;

    assign frac       = acc_i[LO_W-1:0];
    assign frac_half  = frac[LO_W-1];
    assign frac_above = |frac[LO_W-2:0];
    assign high_odd   = acc_i[LO_W];

    // Increment decision: only a fraction of one half or more can round up.
    always_comb begin
        inc_o = 1'b0;
        if (round_en_i && frac_half) begin
            unique case (style_i)
                RND_BIASED:   inc_o = 1'b1;
                RND_UNBIASED: inc_o = frac_above | high_odd;
            endcase
        end
    end

    // Widened sum: the carry out of 0x7FFF lands in a spare bit, not the sign.
    assign sum_o = $signed({acc_i[ACC_W-1], acc_i[ACC_W-1:LO_W]})
                 + $signed({{(SUM_W-1){1'b0}}, inc_o});

    always_comb begin
        if (!$isunknown({acc_i, round_en_i, style_i})) begin
            assert_trunc_keeps_high_R1: assert (round_en_i ||
                sum_o[SUM_W-2:0] == acc_i[ACC_W-1:LO_W])
                else $error("truncation altered the high word");
            assert_no_round_below_half_R2: assert (!(inc_o && (frac < HALF_CODE)))
                else $error("increment with fraction below one half");
            assert_above_half_rounds_R3: assert (!(round_en_i && (frac > HALF_CODE)) || inc_o)
                else $error("fraction above one half did not round up");
            assert_tie_to_even_R4: assert (!(round_en_i && style_i == RND_UNBIASED &&
                frac == HALF_CODE) || (inc_o == acc_i[LO_W]))
                else $error("unbiased tie broken the wrong way");
        end
    end

endmodule

// File: rtl/acc_store_sat.sv
module acc_store_sat #(
    parameter int SUM_W  = 25,
    parameter int WORD_W = 16
) (
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic                    sign_i,
    input  logic                    sat_en_i,
    output logic [WORD_W-1:0]       word_o
);

    localparam logic signed [SUM_W-1:0] POS_LIM =
        {{(SUM_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] NEG_LIM = ~POS_LIM;
    localparam logic [WORD_W-1:0] POS_WORD = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    logic over_pos;
    logic under_neg;

    // The direction of the clamp follows the accumulator's top bit.
    assign over_pos  = !sign_i && (sum_i > POS_LIM);
    assign under_neg =  sign_i && (sum_i < NEG_LIM);

    always_comb begin
        word_o = sum_i[WORD_W-1:0];
        if (sat_en_i) begin
            if (over_pos)       word_o = POS_WORD;
            else if (under_neg) word_o = NEG_WORD;
        end
    end

    always_comb begin
        if (!$isunknown({sum_i, sign_i, sat_en_i})) begin
            assert_clamp_pos_R5: assert (!(sat_en_i && !sign_i &&
                word_o != sum_i[WORD_W-1:0]) || word_o == POS_WORD)
                else $error("positive clamp produced a wrong word");
            assert_clamp_neg_R6: assert (!(sat_en_i && sign_i &&
                word_o != sum_i[WORD_W-1:0]) || word_o == NEG_WORD)
                else $error("negative clamp produced a wrong word");
            assert_in_range_kept_R7: assert (!(sat_en_i && sum_i <= POS_LIM &&
                sum_i >= NEG_LIM) || word_o == sum_i[WORD_W-1:0])
                else $error("in-range value was clamped");
            assert_no_sat_passes_R8: assert (sat_en_i || word_o == sum_i[WORD_W-1:0])
                else $error("word changed with saturation off");
        end
    end

endmodule

// File: rtl/acc_store_conv.sv
module acc_store_conv
    import acc_store_pkg::*;
#(
    parameter  int ACC_W  = 40,
    parameter  int LO_W   = 16,
    parameter  int WORD_W = 16,
    localparam int SUM_W  = ACC_W - LO_W + 1
) (
    input  logic [ACC_W-1:0]  acc_val,
    input  logic              round_en,
    input  logic              round_mode,
    input  logic              sat_en,
    output logic [WORD_W-1:0] store_word
);

    rnd_style_e              style;
    logic signed [SUM_W-1:0] rounded;
    logic                    rnd_inc;

    assign style = rnd_style_e'(round_mode);

    acc_round_unit #(
        .ACC_W (ACC_W),
        .LO_W  (LO_W)
    ) u_round (
        .acc_i      (acc_val),
        .round_en_i (round_en),
        .style_i    (style),
        .sum_o      (rounded),
        .inc_o      (rnd_inc)
    );

    acc_store_sat #(
        .SUM_W  (SUM_W),
        .WORD_W (WORD_W)
    ) u_sat (
        .sum_i    (rounded),
        .sign_i   (acc_val[ACC_W-1]),
        .sat_en_i (sat_en),
        .word_o   (store_word)
    );

    always_comb begin
        if (!$isunknown({acc_val, round_en, rnd_inc})) begin
            assert_mode_ignored_R9: assert (round_en || !rnd_inc)
                else $error("rounding applied while truncating");
        end
    end

endmodule

// File: tb/test_acc_store_conv.sv
`timescale 1ns/1ps
module test_acc_store_conv;

    logic        clk = 1'b0;
    logic [39:0] acc_val;
    logic        round_en, round_mode, sat_en;
    logic [15:0] store_word;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    acc_store_conv i_acc_store_conv (
        .acc_val    (acc_val),
        .round_en   (round_en),
        .round_mode (round_mode),
        .sat_en     (sat_en),
        .store_word (store_word)
    );

    function automatic longint rounded_val(logic [39:0] a, logic r, logic m);
        longint hi;
        logic   inc;
        hi  = longint'($signed(a[39:16]));
        inc = 1'b0;
        if (r) begin
            if (a[15:0] > 16'h8000)       inc = 1'b1;
            else if (a[15:0] == 16'h8000) inc = m ? a[16] : 1'b1;
        end
        return hi + longint'(inc);
    endfunction

    function automatic logic [15:0] model(logic [39:0] a, logic r, logic m, logic s);
        longint v;
        v = rounded_val(a, r, m);
        if (s) begin
            if (v > 32767)       v = 32767;
            else if (v < -32768) v = -32768;
        end
        return v[15:0];
    endfunction

    function automatic string tag_of(logic [39:0] a, logic r, logic m, logic s);
        longint v;
        v = rounded_val(a, r, m);
        if (s && v > 32767)            return "R5";
        if (s && v < -32768)           return "R6";
        if (s)                         return "R7";
        if (!r)                        return "R1";
        if (m && a[15:0] == 16'h8000)  return "R4";
        if (m)                         return "R3";
        return "R2";
    endfunction

    task automatic apply(logic [39:0] a, logic r, logic m, logic s);
        @(posedge clk);
        #1;
        acc_val = a; round_en = r; round_mode = m; sat_en = s;
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [15:0] exp);
        n_checks++;
        if (store_word !== exp) begin
            n_fail++;
            $display("FAIL %s acc=%h rnd=%0b mode=%0b sat=%0b actual=%h expected=%h",
                     tag, acc_val, round_en, round_mode, sat_en, store_word, exp);
        end
    endtask

    task automatic vec(string tag, logic [39:0] a, logic r, logic m, logic s, logic [15:0] exp);
        apply(a, r, m, s);
        check(tag, exp);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] a;
        logic [15:0] w0, w1;
        acc_val = '0; round_en = 0; round_mode = 0; sat_en = 0;
        @(negedge clk);
        check("R1", 16'h0000);
        // R1 truncation
        vec("R1", 40'h00_1234_7FFF, 0, 0, 0, 16'h1234);
        vec("R1", 40'hF0_ABCD_FFFF, 0, 0, 0, 16'hABCD);
        // R2 biased rounding
        vec("R2", 40'h00_1234_7FFF, 1, 0, 0, 16'h1234);
        vec("R2", 40'h00_1234_8000, 1, 0, 0, 16'h1235);
        vec("R2", 40'h00_1235_8000, 1, 0, 0, 16'h1236);
        // R3 unbiased off the tie
        vec("R3", 40'h00_1234_8001, 1, 1, 0, 16'h1235);
        vec("R3", 40'h00_1234_7FFF, 1, 1, 0, 16'h1234);
        // R4 ties
        vec("R4", 40'h00_1234_8000, 1, 1, 0, 16'h1234);
        vec("R4", 40'h00_1235_8000, 1, 1, 0, 16'h1236);
        vec("R4", 40'hFF_FFFF_8000, 1, 1, 1, 16'h0000);
        // R5 positive clamp, including 0x7FFF round carry
        vec("R5", 40'h00_7FFF_8000, 1, 0, 1, 16'h7FFF);
        vec("R5", 40'h00_7FFF_C000, 1, 1, 1, 16'h7FFF);
        vec("R5", 40'h12_3456_0000, 0, 0, 1, 16'h7FFF);
        // R6 negative clamp
        vec("R6", 40'hFF_7FFF_FFFF, 0, 0, 1, 16'h8000);
        vec("R6", 40'h80_0000_0000, 1, 1, 1, 16'h8000);
        // R7 in range
        vec("R7", 40'hFF_8000_0000, 0, 0, 1, 16'h8000);
        vec("R7", 40'hFF_7FFF_FFFF, 1, 0, 1, 16'h8000);
        vec("R7", 40'h00_1234_8000, 1, 0, 1, 16'h1235);
        // R8 wrap with saturation off
        vec("R8", 40'h00_7FFF_8000, 1, 0, 0, 16'h8000);
        vec("R8", 40'h12_3456_0000, 0, 0, 0, 16'h3456);
        vec("R8", 40'h80_0000_0000, 0, 0, 0, 16'h0000);
        // R9 mode ignored when truncating
        apply(40'h00_1235_8000, 0, 0, 0); w0 = store_word;
        apply(40'h00_1235_8000, 0, 1, 0); w1 = store_word;
        n_checks++;
        if (w0 !== w1 || w1 !== 16'h1235) begin
            n_fail++;
            $display("FAIL R9 actual=%h/%h expected=1235/1235", w0, w1);
        end

        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            logic r, m, s;
            int   kind;
            a    = {$urandom, $urandom};
            kind = int'($urandom % 4);
            if (kind == 0) a[39:32] = {8{a[31]}};
            if (kind == 1) begin a[31:16] = 16'h7FFF; a[39:32] = 8'h00; end
            if (kind == 2) a[15:0] = 16'h8000;
            r = 1'(i);
            m = 1'(i >> 1);
            s = 1'(i >> 2);
            apply(a, r, m, s);
            check(tag_of(a, r, m, s), model(a, r, m, s));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule